// File: doc/BRIEF.md
# Multi-Window Mailbox Message Sender

This block pushes a message of arbitrary byte length through a fixed group of `NUM_WIN` adjacent 32-bit mailbox windows. It starts at window `BASE_WIN`. The message lives in an external word buffer, and the block reads that buffer through a port with one cycle of read latency. The block sends the message in rounds. In each round it fills up to `NUM_WIN` windows. The windows are written in descending word order, so the highest window of the group is always the last one written. On the receive side only that highest window raises the notification, so a short round still produces an interrupt.

Between rounds the block waits for the receiver to empty the highest window. On the final round it sends only the bytes that remain: byte positions past the end of the message are forced to zero, and word positions past the end are not written at all. A round whose first word is zero would never raise a receive notification, so the block aborts with an error pulse. A request that arrives while the highest window is still occupied gets a refusal pulse and is not queued.

Top module: `mwin_tx_engine`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o`, `err_o`, `refused_o`, `buf_rd_o` and `win_we_o` are all low.
- R2: A message of L bytes is sent in ceil(L / (4·NUM_WIN)) rounds. Round r uses buffer words r·NUM_WIN through r·NUM_WIN+NUM_WIN−1, where buffer word address k holds message bytes 4k..4k+3 in little-endian order.
- R3: Word i of a round (i counted from 0 within the round) is written to window `BASE_WIN+NUM_WIN−1−i`. Writes go in descending i, so window `BASE_WIN+NUM_WIN−1` gets word 0 and is the last window written in the round.
- R4: In a round with n = ceil(remaining bytes / 4) < NUM_WIN words, the windows for word positions n..NUM_WIN−1 are not written.
- R5: If a round's byte count mod 4 is c ≠ 0, its highest word keeps bytes 0..c−1 (the low 8·c bits) and carries zero in the upper bytes.
- R6: No window is written while `last_full_i` is high. Each round after the first starts only once `last_full_i` has been seen low.
- R7: If word 0 of any round reads as zero, `err_o` pulses for one cycle, nothing is written in that round, and `busy_o` drops in the same cycle.
- R8: A start with nonzero length while idle and while `last_full_i` is high produces a one-cycle `refused_o` pulse in the next cycle. No busy, read or write follows from it.
- R9: An accepted start raises `busy_o` in the next cycle. `busy_o` falls exactly in the cycle of the one-cycle `done_o` or `err_o` pulse, and it is high when sampled after the first start edge.
- R10: A start with length zero yields a `done_o` pulse in the next cycle, with no buffer read and no window write.
- R11: `start_i` is ignored while `busy_o` is high.
- R12: Words other than word 0 of a round may be zero and are sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer request, sampled while idle |
| len_i | input | LEN_W | Message length in bytes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle abort pulse (zero leading word) |
| refused_o | output | 1 | One-cycle pulse: request refused, last window occupied |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_addr_o | output | ADDR_W | Buffer word address |
| buf_data_i | input | 32 | Buffer read data, valid one cycle after the strobe |
| win_we_o | output | 1 | Window write strobe |
| win_idx_o | output | WIN_IDX_W | Window index being written |
| win_data_o | output | 32 | Window write data |
| last_full_i | input | 1 | Highest window of the group still holds unconsumed data |

## Verification
Two functions can meet in the same cycle: a new request arriving, and the highest window being drained. The engine judges the request on the occupancy status it sees in that cycle. The bench holds the status high and raises `start_i`, then drops the status while keeping the request up for one more cycle. It expects exactly one refusal followed by exactly one accepted transfer, with correct window contents. A receiver model with a long drain delay also checks that no window write ever lands while the highest window is occupied.

// File: rtl/mwin_tx_pkg.sv
package mwin_tx_pkg;
  localparam int BYTES_PER_WORD = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_GAP,
    S_LAT,
    S_USE,
    S_LAST
  } tx_state_t;
endpackage

// File: rtl/mwin_round_calc.sv
module mwin_round_calc #(
  parameter int NUM_WIN = 4,
  parameter int LEN_W   = 16,
  parameter int IDX_W   = 2
) (
  input  logic [LEN_W-1:0] bytes_left,
  output logic [LEN_W-1:0] round_bytes,
  output logic [IDX_W-1:0] top_idx,
  output logic [1:0]       tail_bytes
);
  localparam int ROUND_MAX = NUM_WIN * mwin_tx_pkg::BYTES_PER_WORD;

  logic [LEN_W:0] nwords;

  always_comb begin
    if (bytes_left > LEN_W'(ROUND_MAX)) round_bytes = LEN_W'(ROUND_MAX);
    else                                round_bytes = bytes_left;
    nwords     = ({1'b0, round_bytes} + (LEN_W+1)'(3)) >> 2;
    top_idx    = (nwords == '0) ? '0 : IDX_W'(nwords - (LEN_W+1)'(1));
    tail_bytes = round_bytes[1:0];
  end
endmodule

// File: rtl/mwin_byte_mask.sv
module mwin_byte_mask (
  input  logic [31:0] word_in,
  input  logic [1:0]  keep,
  output logic [31:0] word_out
);
  // keep == 0 means all four bytes are kept
  for (genvar b = 0; b < 4; b++) begin : g_byte
    assign word_out[8*b +: 8] = ((keep == 2'd0) || (b < int'(keep))) ? word_in[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/mwin_tx_engine.sv
module mwin_tx_engine #(
  parameter int NUM_WIN   = 4,
  parameter int BASE_WIN  = 8,
  parameter int WIN_IDX_W = 7,
  parameter int LEN_W     = 16,
  parameter int ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 refused_o,
  output logic                 buf_rd_o,
  output logic [ADDR_W-1:0]    buf_addr_o,
  input  logic [31:0]          buf_data_i,
  output logic                 win_we_o,
  output logic [WIN_IDX_W-1:0] win_idx_o,
  output logic [31:0]          win_data_o,
  input  logic                 last_full_i
);
  import mwin_tx_pkg::*;

  localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int LAST_WIN = BASE_WIN + NUM_WIN - 1;

  tx_state_t         state;
  logic [LEN_W-1:0]  bytes_left;
  logic [ADDR_W-1:0] rbase;
  logic [IDX_W-1:0]  cur_i;
  logic              first;
  logic [31:0]       w0;

  logic [LEN_W-1:0]  round_bytes;
  logic [IDX_W-1:0]  top_idx;
  logic [1:0]        tail_bytes;
  logic [31:0]       rd_masked, w0_masked;

  mwin_round_calc #(.NUM_WIN(NUM_WIN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_calc (
    .bytes_left (bytes_left),
    .round_bytes(round_bytes),
    .top_idx    (top_idx),
    .tail_bytes (tail_bytes)
  );

  // only the highest word of a round can be partial
  mwin_byte_mask u_mask_rd (
    .word_in (buf_data_i),
    .keep    ((cur_i == top_idx) ? tail_bytes : 2'd0),
    .word_out(rd_masked)
  );

  mwin_byte_mask u_mask_w0 (
    .word_in (w0),
    .keep    ((top_idx == '0) ? tail_bytes : 2'd0),
    .word_out(w0_masked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      refused_o  <= 1'b0;
      buf_rd_o   <= 1'b0;
      buf_addr_o <= '0;
      win_we_o   <= 1'b0;
      win_idx_o  <= '0;
      win_data_o <= '0;
      bytes_left <= '0;
      rbase      <= '0;
      cur_i      <= '0;
      first      <= 1'b0;
      w0         <= '0;
    end else begin
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      refused_o <= 1'b0;
      buf_rd_o  <= 1'b0;
      win_we_o  <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start_i) begin
            if (len_i == '0) begin
              done_o <= 1'b1;
            end else if (last_full_i) begin
              refused_o <= 1'b1;
            end else begin
              busy_o     <= 1'b1;
              bytes_left <= len_i;
              rbase      <= '0;
              buf_rd_o   <= 1'b1;
              buf_addr_o <= '0;
              first      <= 1'b1;
              state      <= S_LAT;
            end
          end
        end
        S_GAP: state <= S_WAIT;  // let the last write reach the status
        S_WAIT: begin
          if (!last_full_i) begin
            buf_rd_o   <= 1'b1;
            buf_addr_o <= rbase;
            first      <= 1'b1;
            state      <= S_LAT;
          end
        end
        S_LAT: state <= S_USE;
        S_USE: begin
          if (first) begin
            if (buf_data_i == '0) begin
              err_o  <= 1'b1;
              busy_o <= 1'b0;
              state  <= S_IDLE;
            end else begin
              w0    <= buf_data_i;
              first <= 1'b0;
              if (top_idx == '0) begin
                state <= S_LAST;
              end else begin
                cur_i      <= top_idx;
                buf_rd_o   <= 1'b1;
                buf_addr_o <= rbase + ADDR_W'(top_idx);
                state      <= S_LAT;
              end
            end
          end else begin
            win_we_o   <= 1'b1;
            win_idx_o  <= WIN_IDX_W'(LAST_WIN) - WIN_IDX_W'(cur_i);
            win_data_o <= rd_masked;
            if (cur_i == IDX_W'(1)) begin
              state <= S_LAST;
            end else begin
              cur_i      <= cur_i - 1'b1;
              buf_rd_o   <= 1'b1;
              buf_addr_o <= rbase + ADDR_W'(cur_i - 1'b1);
              state      <= S_LAT;
            end
          end
        end
        S_LAST: begin
          win_we_o   <= 1'b1;
          win_idx_o  <= WIN_IDX_W'(LAST_WIN);
          win_data_o <= w0_masked;
          bytes_left <= bytes_left - round_bytes;
          rbase      <= rbase + ADDR_W'(NUM_WIN);
          if (bytes_left == round_bytes) begin
            done_o <= 1'b1;
            busy_o <= 1'b0;
            state  <= S_IDLE;
          end else begin
            state <= S_GAP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: busy ends only with a completion or abort pulse
  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o || err_o));

  // R7 / R9: completion and abort never coincide
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));

  // R8: a refusal never overlaps an active transfer
  p_refuse_idle_r8: assert property (@(posedge clk) disable iff (rst)
    refused_o |-> !busy_o);

  // R3: writes stay inside the window group
  p_win_range_r3: assert property (@(posedge clk) disable iff (rst)
    win_we_o |-> (win_idx_o >= WIN_IDX_W'(BASE_WIN)) && (win_idx_o <= WIN_IDX_W'(LAST_WIN)));

  // R10: no buffer traffic outside a transfer
  p_no_rd_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !buf_rd_o);

  // R6: an occupied last window holds the next round back
  p_hold_full_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && last_full_i) |=> !buf_rd_o);
endmodule

// File: tb/mwin_tx_engine_tb.sv
module mwin_tx_engine_tb;
  localparam int W     = 4;
  localparam int BASE  = 8;
  localparam int LASTW = BASE + W - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] len_i = '0;
  logic        busy_o, done_o, err_o, refused_o, buf_rd_o, win_we_o;
  logic [9:0]  buf_addr_o;
  logic [31:0] buf_data_i;
  logic [6:0]  win_idx_o;
  logic [31:0] win_data_o;
  logic        last_full;
  logic        force_full = 1'b0;

  logic [31:0] mem [0:63];
  logic [31:0] win [0:127];
  logic [31:0] snap [0:63];
  int nsnap = 0, recv_cnt = 0, recv_delay = 3;
  int wr_count = 0, wr_while_full = 0, rd_count = 0;
  int done_cnt = 0, err_cnt = 0, ref_cnt = 0;
  int vectors = 0, miscompares = 0;

  always #4 clk = ~clk;

  assign last_full = (win[LASTW] != 32'h0) || force_full;

  mwin_tx_engine #(.NUM_WIN(W), .BASE_WIN(BASE)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .refused_o(refused_o),
    .buf_rd_o(buf_rd_o), .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
    .win_we_o(win_we_o), .win_idx_o(win_idx_o), .win_data_o(win_data_o),
    .last_full_i(last_full)
  );

  always @(posedge clk) if (buf_rd_o) buf_data_i <= mem[buf_addr_o[5:0]];

  // window group plus receiver model
  always @(posedge clk) begin
    if (rst) begin
      recv_cnt <= 0;
      for (int k = 0; k < 128; k++) win[k] <= 32'h0;
    end else begin
      if (win_we_o) begin
        win[win_idx_o] <= win_data_o;
        wr_count <= wr_count + 1;
        if (last_full) wr_while_full <= wr_while_full + 1;
      end
      if (buf_rd_o)  rd_count <= rd_count + 1;
      if (done_o)    done_cnt <= done_cnt + 1;
      if (err_o)     err_cnt  <= err_cnt + 1;
      if (refused_o) ref_cnt  <= ref_cnt + 1;
      if (recv_cnt != 0) begin
        recv_cnt <= recv_cnt - 1;
        if (recv_cnt == 1)
          for (int k = 0; k < W; k++) win[BASE+k] <= 32'h0;
      end else if (win[LASTW] != 32'h0 && nsnap < 16) begin
        for (int k = 0; k < W; k++) snap[nsnap*W+k] <= win[BASE+k];
        nsnap    <= nsnap + 1;
        recv_cnt <= recv_delay;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_low(input logic [31:0] w, input int c);
    logic [31:0] r = w;
    if (c != 0) r = w & ((32'h1 << (8*c)) - 32'h1);
    return r;
  endfunction

  task automatic fill_mem(input int seed);
    for (int k = 0; k < 64; k++) mem[k] = 32'h01020304 * (k + 1) + 32'h11 * seed + 32'h80000000;
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk); start_i = 1'b1; len_i = 16'(len);
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_end(input int d0, input int e0);
    int t = 0;
    while (done_cnt == d0 && err_cnt == e0 && t < 5000) begin @(negedge clk); t++; end
    repeat (recv_delay + 6) @(negedge clk);
  endtask

  // expected window contents for every round of a message (R2, R3, R4, R5)
  task automatic check_rounds(input int s0, input int len, input string req);
    int rounds = (len + 4*W - 1) / (4*W);
    check(nsnap - s0 == rounds, {req, " round count"}, nsnap - s0, rounds);
    for (int r = 0; r < rounds; r++) begin
      int rb = len - r*4*W;
      int n;
      if (rb > 4*W) rb = 4*W;
      n = (rb + 3) / 4;
      for (int i = 0; i < W; i++) begin
        logic [31:0] e = 32'h0;
        if (i < n) e = keep_low(mem[r*W+i], (i == n-1) ? rb % 4 : 0);
        check(snap[(s0+r)*W + (W-1-i)] == e, req, snap[(s0+r)*W + (W-1-i)], e);
      end
    end
  endtask

  task automatic run_ok(input int len, input string req);
    int s0 = nsnap, d0 = done_cnt, e0 = err_cnt;
    pulse_start(len);
    check(busy_o == 1'b1, "R9 busy after accept", busy_o, 1);
    wait_end(d0, e0);
    check(done_cnt - d0 == 1, {req, " done pulse R9"}, done_cnt - d0, 1);
    check(err_cnt == e0, {req, " no error"}, err_cnt - e0, 0);
    check_rounds(s0, len, req);
  endtask

  task automatic t_reset;
    check({busy_o, done_o, err_o, refused_o, buf_rd_o, win_we_o} == 6'b0, "R1 reset outputs",
          {busy_o, done_o, err_o, refused_o, buf_rd_o, win_we_o}, 0);
  endtask

  task automatic t_full_round;    fill_mem(1); run_ok(16, "R3 full round"); endtask
  task automatic t_multi_round;   fill_mem(2); run_ok(40, "R2 multi round R4"); endtask
  task automatic t_partial;       fill_mem(3); run_ok(6,  "R5 partial two-byte tail"); endtask
  task automatic t_tiny;          fill_mem(4); run_ok(3,  "R5 R4 three-byte message"); endtask
  task automatic t_inner_zero;    fill_mem(5); mem[2] = 32'h0; mem[5] = 32'h0; run_ok(24, "R12 inner zero words"); endtask

  task automatic t_zero_len;
    int w0 = wr_count, r0 = rd_count, d0 = done_cnt;
    pulse_start(0);
    repeat (3) @(negedge clk);
    check(done_cnt - d0 == 1, "R10 done on zero length", done_cnt - d0, 1);
    check(wr_count == w0 && rd_count == r0, "R10 no traffic", wr_count - w0 + rd_count - r0, 0);
  endtask

  task automatic t_err_first;
    int w0 = wr_count, d0 = done_cnt, e0 = err_cnt;
    fill_mem(6); mem[0] = 32'h0;
    pulse_start(8);
    wait_end(d0, e0);
    check(err_cnt - e0 == 1, "R7 abort pulse", err_cnt - e0, 1);
    check(wr_count == w0, "R7 no writes", wr_count - w0, 0);
    check(busy_o == 1'b0 && done_cnt == d0, "R7 idle, no done", {busy_o, 1'b0}, 0);
  endtask

  task automatic t_err_second;
    int w0 = wr_count, s0 = nsnap, d0 = done_cnt, e0 = err_cnt;
    fill_mem(7); mem[4] = 32'h0;
    pulse_start(32);
    wait_end(d0, e0);
    check(err_cnt - e0 == 1 && done_cnt == d0, "R7 abort in round two", err_cnt - e0, 1);
    check(wr_count - w0 == W, "R7 first round only", wr_count - w0, W);
    check(nsnap - s0 == 1, "R7 one delivered round", nsnap - s0, 1);
  endtask

  task automatic t_refuse;
    int w0 = wr_count, r0 = rd_count;
    force_full = 1'b1;
    pulse_start(8);
    repeat (3) @(negedge clk);
    check(ref_cnt == 1, "R8 refusal pulse", ref_cnt, 1);
    check(busy_o == 1'b0 && wr_count == w0 && rd_count == r0, "R8 nothing started",
          wr_count - w0 + rd_count - r0, 0);
    force_full = 1'b0;
  endtask

  // request and drain in the same cycle, then accepted one cycle later
  task automatic t_same_cycle;
    int s0 = nsnap, d0 = done_cnt, e0 = err_cnt, f0 = ref_cnt;
    fill_mem(8);
    force_full = 1'b1;
    @(negedge clk); start_i = 1'b1; len_i = 16'd8;
    @(negedge clk); force_full = 1'b0;
    @(negedge clk); start_i = 1'b0;
    wait_end(d0, e0);
    check(ref_cnt - f0 == 1, "R8 refused while occupied", ref_cnt - f0, 1);
    check(done_cnt - d0 == 1, "R9 accepted after drain", done_cnt - d0, 1);
    check_rounds(s0, 8, "R2 after same-cycle drain");
  endtask

  task automatic t_busy_ignore;
    int s0 = nsnap, d0 = done_cnt, e0 = err_cnt;
    fill_mem(9);
    pulse_start(16);
    repeat (2) @(negedge clk);
    pulse_start(4);
    wait_end(d0, e0);
    check(done_cnt - d0 == 1, "R11 second start ignored", done_cnt - d0, 1);
    check_rounds(s0, 16, "R11 original message intact");
  endtask

  task automatic t_slow_drain;
    recv_delay = 40;
    fill_mem(10);
    run_ok(48, "R6 slow receiver");
    check(wr_while_full == 0, "R6 no write while occupied", wr_while_full, 0);
    recv_delay = 3;
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    fill_mem(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_round();
    t_multi_round();
    t_partial();
    t_tiny();
    t_inner_zero();
    t_zero_len();
    t_err_first();
    t_err_second();
    t_refuse();
    t_same_cycle();
    t_busy_ignore();
    t_slow_drain();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule